// File: doc/BRIEF.md
# Sector Protect Pulse Sequencer

This block drives the in-system protect and unprotect procedures of a flash array through a simple memory command port. A single start strobe, together with a mode bit and a sector number, launches a run. The sequencer raises a hold line that keeps the flash in its elevated protect state for the whole run. It then repeats a fixed cycle: a setup write, a timed pulse, a verify write and a status read. It stops when the status read shows the wanted state or when the retry ceiling is reached.

In protect mode only the chosen sector is treated. In unprotect mode the sequencer first protects every sector in ascending order. It then applies unprotect pulses and walks every sector with a verify read after each pulse. All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. The retry ceilings are separate parameters for the two modes.

Top module: `sect_prot_seq`

## Requirements
- R1: After reset, mem_elev, mem_we, mem_rd, pulse_active, busy, done and fail are all 0.
- R2: start is accepted only while the block is idle; mode_unprot (0 protect, 1 unprotect) and sector are captured then, and a start while busy has no effect on the run.
- R3: mem_elev rises in the cycle after start is accepted and stays high until the run ends; the first write to the memory port comes exactly SETTLE_US microseconds (in clock cycles) after mem_elev rises.
- R4: Every attempt begins with a one-cycle write of 60h on mem_wdata; mem_unprot is 0 for a protect pulse and 1 for an unprotect pulse; in protect mode the address is the requested sector.
- R5: After a 60h write, pulse_active is high for PROT_PULSE_US (protect) or UNPROT_PULSE_US (unprotect) in cycles; the next write is 40h, and a read of the same address follows in the next cycle.
- R6: A protect attempt passes when the read returns 01h. The attempt counter starts at 1 and increments after each failed verify. After PROT_MAX failed verifies the run ends with fail.
- R7: In unprotect mode every sector, from 0 upward, is protected by the R6 procedure before any unprotect pulse. A protect failure ends the run with fail and no unprotect pulse.
- R8: After each unprotect pulse, sectors 0 to NUM_SECT-1 are verified in order and each must read 00h. Any other value starts a new pulse. The run fails after UNPROT_MAX pulses.
- R9: A run ends with done high for exactly one cycle, fail valid in that cycle, and mem_elev low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run (sampled when idle) |
| mode_unprot | input | 1 | 0 = protect one sector, 1 = unprotect all |
| sector | input | SW | Sector to protect in protect mode |
| mem_elev | output | 1 | Hold the flash in the elevated protect state |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rd | output | 1 | One-cycle read strobe; mem_rdata sampled at that edge |
| mem_addr | output | SW | Sector address of the access |
| mem_wdata | output | 8 | Command byte (60h setup, 40h verify) |
| mem_unprot | output | 1 | Flavor of the setup write: 1 = unprotect pulse |
| mem_rdata | input | 8 | Verify status returned by the flash |
| pulse_active | output | 1 | High while a protect or unprotect pulse is timed |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| fail | output | 1 | With done: the device failed |

## Verification
A behavioural flash model in the bench gives each sector a number of protect pulses it needs and a number of unprotect pulses it needs. Random values for these needs, mixed with sectors that are already protected, separate runs that pass on the first attempt from runs that pass after several attempts. Directed needs of exactly the ceiling and one above it show that the pass/fail boundary is at the right count. Unprotect runs where one sector needs more pulses than the others check that the verify walk restarts the pulse. An unprotect run with a sector that cannot be protected checks that no unprotect pulse follows a failed protect-all.

// File: rtl/sps_pkg.sv
// Package: shared state encoding, command bytes and a delay conversion
// helper for the sector protect pulse sequencer.
package sps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SETUP,
        ST_PULSE,
        ST_VWR,
        ST_VRD,
        ST_DONE
    } sps_state_e;

    localparam logic [7:0] CMD_SETUP   = 8'h60;
    localparam logic [7:0] CMD_VERIFY  = 8'h40;
    localparam logic [7:0] STAT_PROT   = 8'h01;
    localparam logic [7:0] STAT_UNPROT = 8'h00;

    // Convert microseconds to clock cycles, never less than one cycle.
    function automatic int unsigned us_to_cyc(longint unsigned hz, longint unsigned us);
        longint unsigned c;
        c = (hz * us) / 64'd1000000;
        return (c == 0) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/sps_timer.sv
// Down-counting delay timer. A load of length L keeps zero low for the
// next L-1 cycles, so a wait state entered on the load lasts L cycles.
// Assumes len >= 1.
module sps_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= len - 1'b1;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sps_attempts.sv
// Attempt counter. A clear sets it to 1, a bump adds one. at_limit says
// that the current attempt is the last one allowed by limit.
module sps_attempts #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bump,
    input  logic [W-1:0] limit,
    output logic         at_limit
);
    logic [W-1:0] count;

    // Track the number of the attempt in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= W'(1);
        else if (clear)  count <= W'(1);
        else if (bump)   count <= count + 1'b1;
    end

    assign at_limit = (count >= limit);
endmodule

// File: rtl/sps_fsm.sv
// Run controller: sequences settle, setup write, pulse, verify write and
// verify read; walks sectors for protect-all and unprotect verify.
// Assumes NUM_SECT >= 2 and that mem_rdata is valid at the read edge.
module sps_fsm
    import sps_pkg::*;
#(
    parameter int NUM_SECT   = 32,
    parameter int SW         = 5,
    parameter int TW         = 16,
    parameter int SETTLE_CYC = 50,
    parameter int PROT_CYC   = 7500,
    parameter int UNP_CYC    = 7500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_unprot,
    input  logic [SW-1:0] sector,
    input  logic [7:0]    mem_rdata,
    input  logic          tmr_zero,
    input  logic          at_limit,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_len,
    output logic          ctr_clear,
    output logic          ctr_bump,
    output logic          unp_phase,
    output logic          mem_elev,
    output logic          mem_we,
    output logic          mem_rd,
    output logic [SW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          pulse_active,
    output logic          busy,
    output logic          done,
    output logic          fail
);
    sps_state_e    state;
    logic [SW-1:0] sec;
    logic          mode_q;
    logic          unp_q;
    logic          fail_q;
    logic          last_sec;
    logic          prot_ok;
    logic          unp_ok;
    logic          accept;

    assign last_sec = (sec == SW'(NUM_SECT - 1));
    assign prot_ok  = (mem_rdata == STAT_PROT);
    assign unp_ok   = (mem_rdata == STAT_UNPROT);
    assign accept   = (state == ST_IDLE) && start;

    // State, sector walk, phase and failure bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sec    <= '0;
            mode_q <= 1'b0;
            unp_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_SETTLE;
                    mode_q <= mode_unprot;
                    unp_q  <= 1'b0;
                    fail_q <= 1'b0;
                    sec    <= mode_unprot ? '0 : sector;
                end
                ST_SETTLE: if (tmr_zero) state <= ST_SETUP;
                ST_SETUP:  state <= ST_PULSE;
                ST_PULSE:  if (tmr_zero) state <= ST_VWR;
                ST_VWR:    state <= ST_VRD;
                ST_VRD: begin
                    if (!unp_q) begin
                        if (prot_ok) begin
                            if (!mode_q) begin
                                state <= ST_DONE;
                            end else begin
                                state <= ST_SETUP;
                                if (last_sec) begin
                                    unp_q <= 1'b1;
                                    sec   <= '0;
                                end else begin
                                    sec   <= sec + 1'b1;
                                end
                            end
                        end else if (at_limit) begin
                            fail_q <= 1'b1;
                            state  <= ST_DONE;
                        end else begin
                            state <= ST_SETUP;
                        end
                    end else begin
                        if (unp_ok) begin
                            if (last_sec) begin
                                state <= ST_DONE;
                            end else begin
                                sec   <= sec + 1'b1;
                                state <= ST_VWR;
                            end
                        end else if (at_limit) begin
                            fail_q <= 1'b1;
                            state  <= ST_DONE;
                        end else begin
                            sec   <= '0;
                            state <= ST_SETUP;
                        end
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Timer control: settle delay on accept, pulse length on setup write.
    always_comb begin
        tmr_load = accept || (state == ST_SETUP);
        if (state == ST_IDLE) tmr_len = TW'(SETTLE_CYC);
        else if (unp_q)       tmr_len = TW'(UNP_CYC);
        else                  tmr_len = TW'(PROT_CYC);
    end

    // Attempt counter control: restart per sector/phase, bump on retry.
    always_comb begin
        ctr_clear = accept ||
                    ((state == ST_VRD) && !unp_q && prot_ok && mode_q);
        ctr_bump  = (state == ST_VRD) && !at_limit &&
                    (unp_q ? !unp_ok : !prot_ok);
    end

    // Memory port and status outputs decoded from the state register.
    always_comb begin
        mem_we       = (state == ST_SETUP) || (state == ST_VWR);
        mem_rd       = (state == ST_VRD);
        mem_wdata    = (state == ST_SETUP) ? CMD_SETUP : CMD_VERIFY;
        mem_addr     = sec;
        mem_elev     = (state != ST_IDLE) && (state != ST_DONE);
        pulse_active = (state == ST_PULSE);
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
        fail         = (state == ST_DONE) && fail_q;
        unp_phase    = unp_q;
    end
endmodule

// File: rtl/sect_prot_seq.sv
// Top level of the sector protect pulse sequencer. Converts microsecond
// parameters to cycles and ties controller, timer and attempt counter.
// Assumes the flash honours the 60h/40h protocol on the port.
module sect_prot_seq
    import sps_pkg::*;
#(
    parameter longint unsigned CLK_HZ          = 50_000_000,
    parameter int              NUM_SECT        = 32,
    parameter int              SETTLE_US       = 1,
    parameter int              PROT_PULSE_US   = 150,
    parameter int              UNPROT_PULSE_US = 15000,
    parameter int              PROT_MAX        = 25,
    parameter int              UNPROT_MAX      = 1000,
    localparam int             SW              = $clog2(NUM_SECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_unprot,
    input  logic [SW-1:0] sector,
    output logic          mem_elev,
    output logic          mem_we,
    output logic          mem_rd,
    output logic [SW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_unprot,
    input  logic [7:0]    mem_rdata,
    output logic          pulse_active,
    output logic          busy,
    output logic          done,
    output logic          fail
);
    localparam int SETTLE_CYC = int'(us_to_cyc(CLK_HZ, longint'(SETTLE_US)));
    localparam int PROT_CYC   = int'(us_to_cyc(CLK_HZ, longint'(PROT_PULSE_US)));
    localparam int UNP_CYC    = int'(us_to_cyc(CLK_HZ, longint'(UNPROT_PULSE_US)));
    localparam int MAX_CYC    = (SETTLE_CYC > PROT_CYC) ?
                                ((SETTLE_CYC > UNP_CYC) ? SETTLE_CYC : UNP_CYC) :
                                ((PROT_CYC > UNP_CYC) ? PROT_CYC : UNP_CYC);
    localparam int TW         = $clog2(MAX_CYC + 1);
    localparam int MAX_TRY    = (PROT_MAX > UNPROT_MAX) ? PROT_MAX : UNPROT_MAX;
    localparam int CW         = $clog2(MAX_TRY + 2);

    logic          tmr_load;
    logic [TW-1:0] tmr_len;
    logic          tmr_zero;
    logic          ctr_clear;
    logic          ctr_bump;
    logic          at_limit;
    logic          unp_phase;
    logic [CW-1:0] limit;

    // Retry ceiling chosen by the active phase.
    assign limit      = unp_phase ? CW'(UNPROT_MAX) : CW'(PROT_MAX);
    assign mem_unprot = unp_phase;

    sps_fsm #(
        .NUM_SECT  (NUM_SECT),
        .SW        (SW),
        .TW        (TW),
        .SETTLE_CYC(SETTLE_CYC),
        .PROT_CYC  (PROT_CYC),
        .UNP_CYC   (UNP_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_unprot (mode_unprot),
        .sector      (sector),
        .mem_rdata   (mem_rdata),
        .tmr_zero    (tmr_zero),
        .at_limit    (at_limit),
        .tmr_load    (tmr_load),
        .tmr_len     (tmr_len),
        .ctr_clear   (ctr_clear),
        .ctr_bump    (ctr_bump),
        .unp_phase   (unp_phase),
        .mem_elev    (mem_elev),
        .mem_we      (mem_we),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pulse_active(pulse_active),
        .busy        (busy),
        .done        (done),
        .fail        (fail)
    );

    sps_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .len  (tmr_len),
        .zero (tmr_zero)
    );

    sps_attempts #(.W(CW)) u_attempts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .bump    (ctr_bump),
        .limit   (limit),
        .at_limit(at_limit)
    );
endmodule

// File: rtl/sps_checker.sv
// Protocol checker for the sector protect pulse sequencer, bound to the
// top level. Pulse lengths are measured with a counter, not $past depth.
module sps_checker #(
    parameter int PROT_CYC = 7500,
    parameter int UNP_CYC  = 7500
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mem_elev,
    input logic       mem_we,
    input logic       mem_rd,
    input logic [7:0] mem_wdata,
    input logic       pulse_active,
    input logic       done,
    input logic       fail
);
    int unsigned plen;

    // Length of the current or just-ended pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)            plen <= 0;
        else if (pulse_active) plen <= plen + 1;
        else                   plen <= 0;
    end

    AST_ACCESS_ELEVATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_rd) |-> mem_elev);                                   // R3
    AST_PULSE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_active) |-> ($past(mem_we) && $past(mem_wdata) == 8'h60)); // R4
    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_active) |-> (plen == PROT_CYC || plen == UNP_CYC));     // R5
    AST_READ_AFTER_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ($past(mem_we) && $past(mem_wdata) == 8'h40));           // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R9
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);                                                     // R9
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_elev);                                                // R9
endmodule

bind sect_prot_seq sps_checker #(
    .PROT_CYC(PROT_CYC),
    .UNP_CYC (UNP_CYC)
) u_sps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_elev    (mem_elev),
    .mem_we      (mem_we),
    .mem_rd      (mem_rd),
    .mem_wdata   (mem_wdata),
    .pulse_active(pulse_active),
    .done        (done),
    .fail        (fail)
);

// File: tb/test_sect_prot_seq.sv
// Self-checking bench with a behavioural flash model.
module test_sect_prot_seq;
    localparam int NS    = 4;
    localparam int SETC  = 3;
    localparam int PROTC = 20;
    localparam int UNPC  = 50;
    localparam int PMAX  = 25;
    localparam int UMAX  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_unprot = 1'b0;
    logic [1:0] sector = '0;
    logic       mem_elev, mem_we, mem_rd, mem_unprot, pulse_active, busy, done, fail;
    logic [1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    int   n_checks = 0;
    int   n_errors = 0;

    // flash model state and monitor counters (all written from one process)
    int   need_p[NS];
    int   need_u[NS];
    logic prot_q[NS];
    int   cyc = 0, n_pp = 0, n_up = 0, bad_gap = 0, viol = 0, order_err = 0;
    int   wrong_addr = 0, n_done = 0, elev_err = 0, settle_meas = -1;
    int   last_setup = 0, elev_rise = 0, last_paddr = 0;
    bit   last_fail = 0, have_setup = 0, setup_unp = 0, first_we = 0;
    bit   elev_prev = 0, first_unp = 0, cur_mode = 0;
    int   cur_target = 0;

    always #10 clk = ~clk;

    assign mem_rdata = prot_q[mem_addr] ? 8'h01 : 8'h00;

    sect_prot_seq #(
        .CLK_HZ(1_000_000), .NUM_SECT(NS), .SETTLE_US(SETC),
        .PROT_PULSE_US(PROTC), .UNPROT_PULSE_US(UNPC),
        .PROT_MAX(PMAX), .UNPROT_MAX(UMAX)
    ) i_sect_prot_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_unprot(mode_unprot),
        .sector(sector), .mem_elev(mem_elev), .mem_we(mem_we), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_unprot(mem_unprot),
        .mem_rdata(mem_rdata), .pulse_active(pulse_active), .busy(busy),
        .done(done), .fail(fail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bench expectation: pulses a protect of one sector takes.
    function automatic int exp_ppulses(input bit pre, input int need);
        if (pre) return 1;
        return (need < PMAX) ? need : PMAX;
    endfunction

    // Monitor and flash model, sampled at the falling edge.
    task automatic monitor();
        forever begin
            @(negedge clk);
            cyc++;
            if (mem_elev && !elev_prev) begin
                elev_rise = cyc;
                first_we  = 0;
            end
            if (mem_we) begin
                if (!first_we) begin
                    settle_meas = cyc - elev_rise;
                    first_we    = 1;
                end
                if (mem_wdata == 8'h60) begin
                    last_setup = cyc;
                    setup_unp  = mem_unprot;
                    have_setup = 1;
                    if (!mem_unprot) begin
                        n_pp++;
                        if (!cur_mode && int'(mem_addr) != cur_target) wrong_addr++;
                        if (int'(mem_addr) < last_paddr) order_err++;
                        last_paddr = int'(mem_addr);
                        if (need_p[mem_addr] > 0) need_p[mem_addr]--;
                        if (need_p[mem_addr] == 0) prot_q[mem_addr] = 1'b1;
                    end else begin
                        if (first_unp)
                            for (int s = 0; s < NS; s++) if (!prot_q[s]) viol++;
                        first_unp = 0;
                        n_up++;
                        for (int s = 0; s < NS; s++) begin
                            if (need_u[s] > 0) need_u[s]--;
                            if (need_u[s] == 0) prot_q[s] = 1'b0;
                        end
                    end
                end else if (mem_wdata == 8'h40 && have_setup) begin
                    if (cyc - last_setup != (setup_unp ? UNPC : PROTC) + 1) bad_gap++;
                    have_setup = 0;
                end
            end
            if (done) begin
                n_done++;
                last_fail = fail;
                if (mem_elev) elev_err++;
            end
            elev_prev = mem_elev;
        end
    endtask

    // One run with expectations computed from the model before it starts.
    task automatic run_op(input bit m, input int s, input bit poke);
        int  e_pp, e_up, mx, t, s_pp, s_up, s_gap, s_viol, s_ord, s_wa, s_done, s_ee;
        bit  e_fail;
        e_pp = 0; e_up = 0; e_fail = 0;
        if (!m) begin
            e_pp   = exp_ppulses(prot_q[s], need_p[s]);
            e_fail = !prot_q[s] && need_p[s] > PMAX;
        end else begin
            for (int k = 0; k < NS; k++) begin
                if (!e_fail) begin
                    e_pp += exp_ppulses(prot_q[k], need_p[k]);
                    if (!prot_q[k] && need_p[k] > PMAX) e_fail = 1;
                end
            end
            if (!e_fail) begin
                mx = 1;
                for (int k = 0; k < NS; k++) if (need_u[k] > mx) mx = need_u[k];
                e_up   = (mx < UMAX) ? mx : UMAX;
                e_fail = mx > UMAX;
            end
        end
        s_pp = n_pp; s_up = n_up; s_gap = bad_gap; s_viol = viol; s_ord = order_err;
        s_wa = wrong_addr; s_done = n_done; s_ee = elev_err;
        cur_mode = m; cur_target = s; last_paddr = 0; first_unp = 1;
        @(negedge clk);
        start = 1; mode_unprot = m; sector = 2'(s);
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1; mode_unprot = !m; sector = 2'(s + 1);
            @(negedge clk);
            start = 0;
        end
        t = 0;
        while (n_done == s_done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        check(n_done - s_done == 1, "R9 one done per run", n_done - s_done, 1);
        check(last_fail == e_fail, m ? "R8 fail flag" : "R6 fail flag", last_fail, e_fail);
        check(n_pp - s_pp == e_pp, m ? "R7 protect pulses" : "R6 protect pulses", n_pp - s_pp, e_pp);
        check(n_up - s_up == e_up, "R8 unprotect pulses", n_up - s_up, e_up);
        check(bad_gap == s_gap, "R5 pulse to verify gap", bad_gap - s_gap, 0);
        check(viol == s_viol && order_err == s_ord, "R7 protect-all first",
              viol - s_viol + order_err - s_ord, 0);
        check(wrong_addr == s_wa, "R4 setup address", wrong_addr - s_wa, 0);
        check(settle_meas == SETC, "R3 settle delay", settle_meas, SETC);
        check(elev_err == s_ee && !mem_elev && !busy, "R9 released at end", elev_err - s_ee, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(!busy && n_done - s_done == 1, "R2 start while busy ignored", n_done - s_done, 1);
        end
    endtask

    task automatic set_sector(input int s, input int np, input int nu, input bit p);
        need_p[s] = np; need_u[s] = nu; prot_q[s] = p;
    endtask

    initial begin
        void'($urandom(32'h5EC7));
        for (int s = 0; s < NS; s++) set_sector(s, 1, 1, 1'b0);
        fork
            monitor();
        join_none
        repeat (4) @(negedge clk);
        check(!mem_elev && !mem_we && !mem_rd && !pulse_active && !busy && !done && !fail,
              "R1 reset state", int'(busy), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!mem_elev && !busy && !done, "R1 idle after reset", int'(mem_elev), 0);

        // Directed corner cases.
        set_sector(2, 3, 1, 1'b0);  run_op(1'b0, 2, 1'b0);          // R6 retries
        set_sector(1, 1, 1, 1'b1);  run_op(1'b0, 1, 1'b1);          // R2 poke
        set_sector(0, PMAX, 1, 1'b0);      run_op(1'b0, 0, 1'b0);   // R6 at ceiling
        set_sector(3, PMAX + 1, 1, 1'b0);  run_op(1'b0, 3, 1'b0);   // R6 over ceiling
        for (int s = 0; s < NS; s++) set_sector(s, 2, 1, 1'b0);
        need_u[2] = 4;               run_op(1'b1, 0, 1'b0);         // R8 restart walk
        for (int s = 0; s < NS; s++) set_sector(s, 1, UMAX + 1, 1'b1);
        run_op(1'b1, 0, 1'b0);                                       // R8 ceiling fail
        for (int s = 0; s < NS; s++) set_sector(s, 1, 1, 1'b0);
        need_p[1] = PMAX + 3;        run_op(1'b1, 0, 1'b0);          // R7 protect fail

        // Constrained random runs.
        for (int i = 0; i < 30; i++) begin
            bit m;
            int s;
            m = 1'($urandom_range(0, 1));
            s = int'($urandom_range(0, NS - 1));
            for (int k = 0; k < NS; k++)
                set_sector(k, int'($urandom_range(1, 5)), int'($urandom_range(1, UMAX + 1)),
                           1'($urandom_range(0, 1)));
            if ($urandom_range(0, 7) == 0) need_p[s] = PMAX + 1;
            run_op(m, s, 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule